// File: doc/BRIEF.md
# Configuration File Header Scanner

The block sits in front of a configuration loader and inspects the header of a configuration file as it streams past, one byte per accepted valid/ready handshake. After a `start` pulse it first requires the stream to open with a fixed 13-byte signature: 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. It then walks a chain of tagged sections. Each section is one ASCII tag byte, a big-endian length, and that many content bytes. The scan stops when the section whose tag was requested at `start` is reached, and the block reports that section's payload length.

The result is given as three levels: `done`, `found` and `err`, and a 32-bit `sect_len`. These hold until the next `start`. Once the result is up, `in_ready` stays low, so the stream is left parked on the first payload byte of the found section. The loader can then read that many bytes itself. Lengths are clamped and the walk is bounded, so a corrupt header cannot send the scan far into the file.

States: IDLE (after reset), MAGIC (matching the signature), TAG (reading a section tag), LEN (reading the length field), SKIP (discarding content) and DONE (result held). Transitions:
- IDLE→MAGIC on start.
- MAGIC→DONE on a mismatching byte.
- MAGIC→TAG after the last signature byte.
- TAG→LEN on a tag in range.
- TAG→DONE on a tag out of range or an exhausted window.
- LEN→DONE on the requested tag.
- LEN→SKIP when the length is non-zero.
- LEN→TAG when the length is zero.
- SKIP→TAG when the skip completes or the window runs out.
- DONE→MAGIC on start.

Top module: `hdr_scan`

## Requirements
- R1: After reset, in_ready, done, found and err are 0 and sect_len is 0.
- R2: The requested tag is taken from want_tag only in the cycle start is accepted, in IDLE or DONE. A start pulse or a want_tag change while a scan is running has no effect on its result.
- R3: Each of the first 13 accepted bytes must equal the signature 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01, in that order. The first mismatching byte ends the scan with done=1, err=1, found=0, and no further byte is accepted. found and err are never 1 together.
- R4: After the signature, each section is a tag byte, then a big-endian length, then content. The length field is 4 bytes for tag 0x65 ('e') and 2 bytes for any other tag. The content of a section whose tag is not the requested one is consumed and discarded.
- R5: When the requested tag's length field completes, the block sets done=1, found=1, err=0 and sect_len to the (clamped) length. in_ready is 0 from then on, so the total number of bytes accepted equals the header bytes up to and including the length field.
- R6: A tag byte below 0x61 or above 0x65 ends the scan with done=1, found=0, err=0, after that tag byte is accepted.
- R7: A 2-byte length above 64 is treated as 64, both when it is reported and when content is skipped. Lengths of 64 or less are used as they are.
- R8: A 4-byte length above 307200 is treated as 307200. Lengths of 307200 or less are used as they are.
- R9: Bytes accepted after the signature are counted, covering tag, length and content bytes. Content skipping stops once the count reaches 100. No tag is read once the count is 100 or more; the scan then ends not-found. A tag read at count 99 is still processed, including its length field.
- R10: done, found, err and sect_len hold their values while no start arrives. A start in DONE clears them in the next cycle and begins a new scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan (accepted in IDLE or DONE) |
| want_tag | input | 8 | Requested section tag, sampled with start |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| done | output | 1 | Result is available and held |
| found | output | 1 | Requested section reached |
| err | output | 1 | Signature mismatch |
| sect_len | output | 32 | Clamped length of the found section, else 0 |

## Verification
Several stream shapes are driven. Headers whose requested section comes first, later, or after a zero-length section tell correct tag matching apart from off-by-one skipping. A 4-byte length on a skipped section separates the per-tag field width. Signature faults at a middle and at the final position, and tags just outside the letter range on both sides, separate error from not-found. Lengths just below, at and above each cap check the clamp comparison. Two long headers, one ending exactly at the window edge and one crossing it, pin down the byte budget. Gapped valid and a start pulse mid-scan show that the accepted-byte count and the result depend only on handshakes and on the tag sampled at start.

// File: rtl/hdr_scan_pkg.sv
package hdr_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAGIC,
        ST_TAG,
        ST_LEN,
        ST_SKIP,
        ST_DONE
    } scan_st_t;

    localparam int LONG_FIELD_BYTES  = 4;
    localparam int SHORT_FIELD_BYTES = 2;

    // Opening signature byte at position i (positions 0..12).
    function automatic logic [7:0] magic_byte(input logic [3:0] i);
        logic [7:0] b;
        unique case (i)
            4'd0:                       b = 8'h00;
            4'd1:                       b = 8'h09;
            4'd2, 4'd4, 4'd6, 4'd8:     b = 8'h0F;
            4'd3, 4'd5, 4'd7, 4'd9:     b = 8'hF0;
            4'd10, 4'd11:               b = 8'h00;
            4'd12:                      b = 8'h01;
            default:                    b = 8'hXX;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/hdr_magic_cmp.sv
module hdr_magic_cmp
    import hdr_scan_pkg::*;
#(
    parameter int MAGIC_LEN = 13,
    localparam int IDX_W    = $clog2(MAGIC_LEN)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic             hit,
    output logic             last
);
    logic [3:0] idx4;

    assign idx4 = 4'(idx);
    assign hit  = (din == magic_byte(idx4));
    assign last = (idx == IDX_W'(MAGIC_LEN - 1));

endmodule

// File: rtl/hdr_len_shift.sv
module hdr_len_shift #(
    parameter int LEN_W     = 32,
    parameter int SHORT_CAP = 64,
    parameter int LONG_CAP  = 307200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic [7:0]       din,
    input  logic             is_long,
    output logic [LEN_W-1:0] capped_next
);
    logic [LEN_W-1:0] acc;
    logic [LEN_W-1:0] acc_next;

    assign acc_next = (acc << 8) | LEN_W'(din);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (shift) begin
            acc <= acc_next;
        end
    end

    // Clamp the value that includes the byte now on din.
    always_comb begin
        if (is_long) begin
            capped_next = (acc_next > LEN_W'(LONG_CAP)) ? LEN_W'(LONG_CAP) : acc_next;
        end else begin
            capped_next = (acc_next > LEN_W'(SHORT_CAP)) ? LEN_W'(SHORT_CAP) : acc_next;
        end
    end

endmodule

// File: rtl/hdr_win_ctr.sv
module hdr_win_ctr #(
    parameter int SEARCH_WIN = 100,
    localparam int CNT_W     = $clog2(SEARCH_WIN + 1) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic full,
    output logic at_edge
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign full    = (cnt >= CNT_W'(SEARCH_WIN));
    assign at_edge = ((cnt + 1'b1) >= CNT_W'(SEARCH_WIN));

endmodule

// File: rtl/hdr_scan.sv
module hdr_scan
    import hdr_scan_pkg::*;
#(
    parameter int         MAGIC_LEN  = 13,
    parameter int         SEARCH_WIN = 100,
    parameter int         SHORT_CAP  = 64,
    parameter int         LONG_CAP   = 307200,
    parameter int         LEN_W      = 32,
    parameter logic [7:0] LONG_TAG   = 8'h65,
    parameter logic [7:0] TAG_FIRST  = 8'h61,
    parameter logic [7:0] TAG_LAST   = 8'h65
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       want_tag,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             done,
    output logic             found,
    output logic             err,
    output logic [LEN_W-1:0] sect_len
);
    localparam int IDX_W = $clog2(MAGIC_LEN);
    localparam int FLD_W = $clog2(LONG_FIELD_BYTES + 1);

    scan_st_t         st, st_nxt;
    logic [IDX_W-1:0] magic_idx;
    logic [7:0]       want_q;
    logic [7:0]       cur_tag;
    logic [FLD_W-1:0] fld_left;
    logic [LEN_W-1:0] skip_left;
    logic             found_q, err_q;
    logic [LEN_W-1:0] len_q;

    logic             take;
    logic             restart;
    logic             magic_hit, magic_last;
    logic             win_full, win_edge;
    logic [LEN_W-1:0] len_capped;
    logic             tag_in_range;
    logic             fld_last;
    logic             tag_is_want;
    logic             walk_take;

    // ---------------- helpers ----------------
    hdr_magic_cmp #(.MAGIC_LEN(MAGIC_LEN)) u_magic (
        .idx  (magic_idx),
        .din  (in_data),
        .hit  (magic_hit),
        .last (magic_last)
    );

    hdr_len_shift #(
        .LEN_W     (LEN_W),
        .SHORT_CAP (SHORT_CAP),
        .LONG_CAP  (LONG_CAP)
    ) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (st == ST_TAG),
        .shift       (take && (st == ST_LEN)),
        .din         (in_data),
        .is_long     (cur_tag == LONG_TAG),
        .capped_next (len_capped)
    );

    hdr_win_ctr #(.SEARCH_WIN(SEARCH_WIN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .inc     (walk_take),
        .full    (win_full),
        .at_edge (win_edge)
    );

    assign take         = in_valid && in_ready;
    assign restart      = start && ((st == ST_IDLE) || (st == ST_DONE));
    assign tag_in_range = (in_data >= TAG_FIRST) && (in_data <= TAG_LAST);
    assign fld_last     = (fld_left == FLD_W'(1));
    assign tag_is_want  = (cur_tag == want_q);
    assign walk_take    = take && ((st == ST_TAG) || (st == ST_LEN) || (st == ST_SKIP));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (start) st_nxt = ST_MAGIC;
            end
            ST_MAGIC: begin
                if (take) begin
                    if (!magic_hit)     st_nxt = ST_DONE;
                    else if (magic_last) st_nxt = ST_TAG;
                end
            end
            ST_TAG: begin
                if (win_full) begin
                    st_nxt = ST_DONE;
                end else if (take) begin
                    st_nxt = tag_in_range ? ST_LEN : ST_DONE;
                end
            end
            ST_LEN: begin
                if (take && fld_last) begin
                    if (tag_is_want)            st_nxt = ST_DONE;
                    else if (len_capped == '0)  st_nxt = ST_TAG;
                    else                        st_nxt = ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (take && ((skip_left == LEN_W'(1)) || win_edge)) st_nxt = ST_TAG;
            end
            ST_DONE: begin
                if (start) st_nxt = ST_MAGIC;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            magic_idx <= '0;
            want_q    <= '0;
            cur_tag   <= '0;
            fld_left  <= '0;
            skip_left <= '0;
            found_q   <= 1'b0;
            err_q     <= 1'b0;
            len_q     <= '0;
        end else if (restart) begin
            magic_idx <= '0;
            want_q    <= want_tag;
            found_q   <= 1'b0;
            err_q     <= 1'b0;
            len_q     <= '0;
        end else if (take) begin
            unique case (st)
                ST_MAGIC: begin
                    magic_idx <= magic_idx + 1'b1;
                    if (!magic_hit) err_q <= 1'b1;
                end
                ST_TAG: begin
                    cur_tag  <= in_data;
                    fld_left <= (in_data == LONG_TAG) ? FLD_W'(LONG_FIELD_BYTES)
                                                      : FLD_W'(SHORT_FIELD_BYTES);
                end
                ST_LEN: begin
                    fld_left <= fld_left - 1'b1;
                    if (fld_last) begin
                        if (tag_is_want) begin
                            found_q <= 1'b1;
                            len_q   <= len_capped;
                        end else begin
                            skip_left <= len_capped;
                        end
                    end
                end
                ST_SKIP: begin
                    skip_left <= skip_left - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready = 1'b0;
        unique case (st)
            ST_MAGIC, ST_LEN, ST_SKIP: in_ready = 1'b1;
            ST_TAG:                    in_ready = !win_full;
            default:                   in_ready = 1'b0;
        endcase
        done     = (st == ST_DONE);
        found    = found_q;
        err      = err_q;
        sect_len = len_q;
    end

endmodule

// File: rtl/hdr_scan_chk.sv
module hdr_scan_chk #(
    parameter int LEN_W    = 32,
    parameter int LONG_CAP = 307200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_ready,
    input logic             done,
    input logic             found,
    input logic             err,
    input logic [LEN_W-1:0] sect_len
);
    // R5: nothing is consumed while a result is shown
    p_ready_off_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R5: found only ever appears with done
    p_found_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done);

    // R3: error and found are exclusive
    p_excl_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && err));

    // R8: a reported length never exceeds the long cap
    p_len_capped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (sect_len <= LEN_W'(LONG_CAP)));

    // R10: result held while no start arrives
    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(found) && $stable(err) && $stable(sect_len)));

    // R10: start in DONE clears the result
    p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && !found && !err && (sect_len == '0)));

endmodule

bind hdr_scan hdr_scan_chk #(.LEN_W(LEN_W), .LONG_CAP(LONG_CAP)) u_hdr_scan_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_ready (in_ready),
    .done     (done),
    .found    (found),
    .err      (err),
    .sect_len (sect_len)
);

// File: tb/test_hdr_scan.sv
module test_hdr_scan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  want_tag = 8'h00;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        done;
    logic        found;
    logic        err;
    logic [31:0] sect_len;

    always #5 clk = ~clk;

    hdr_scan i_hdr_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .want_tag (want_tag),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .done     (done),
        .found    (found),
        .err      (err),
        .sect_len (sect_len)
    );

    typedef struct {
        bit          f;
        bit          e;
        logic [31:0] len;
        int          n;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    logic [7:0]  strm[$];
    int          taken = 0;
    int          nvec = 0;
    int          nbad = 0;
    bit          done_q = 1'b0;
    bit          finished = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void put(input logic [7:0] b);
        strm.push_back(b);
    endfunction

    function automatic void put_magic();
        put(8'h00); put(8'h09);
        for (int i = 0; i < 4; i++) begin put(8'h0F); put(8'hF0); end
        put(8'h00); put(8'h00); put(8'h01);
    endfunction

    function automatic void put_fill(input int n);
        for (int i = 0; i < n; i++) put(8'h55);
    endfunction

    // Monitor: pops the expectation when a result appears
    always @(negedge clk) begin
        if (done && !done_q) begin
            if (exp_q.size() == 0) begin
                chk("R5", "unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "found", 32'(found), 32'(e.f));
                chk(e.req, "err", 32'(err), 32'(e.e));
                chk(e.req, "sect_len", sect_len, e.len);
                chk(e.req, "bytes accepted", 32'(taken), 32'(e.n));
                chk(e.req, "in_ready at done", 32'(in_ready), 32'd0);
            end
        end
        done_q = done;
    end

    // Driver: pushes expectation, starts, feeds stream until done
    task automatic run_case(input logic [7:0] want, input bit ef, input bit ee,
                            input logic [31:0] el, input int en, input string req,
                            input bit gappy, input int glitch_at);
        int cyc;
        exp_q.push_back('{ef, ee, el, en, req});
        @(negedge clk);
        want_tag = want;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        want_tag = 8'h7A;
        taken    = 0;
        cyc      = 0;
        while (!done && cyc < 2000) begin
            in_valid = (taken < strm.size()) && !(gappy && (cyc % 2 == 1));
            in_data  = (taken < strm.size()) ? strm[taken] : 8'h00;
            if (glitch_at >= 0 && taken == glitch_at) begin
                start    = 1'b1;
                want_tag = 8'h61;
            end else begin
                start    = 1'b0;
                want_tag = 8'h7A;
            end
            if (in_valid && in_ready) taken++;
            cyc++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        start    = 1'b0;
        repeat (3) @(negedge clk);
        // R10: result held with no start
        chk("R10", "hold done", 32'(done), 32'd1);
        chk("R10", "hold found", 32'(found), 32'(ef));
        chk("R10", "hold sect_len", sect_len, el);
        strm.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "in_ready", 32'(in_ready), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "found", 32'(found), 32'(0));
        chk("R1", "err", 32'(err), 32'd0);
        chk("R1", "sect_len", sect_len, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4/R5: skip a short section, find a long-field one
        put_magic(); put(8'h61); put(8'h00); put(8'h03); put_fill(3);
        put(8'h65); put(8'h00); put(8'h01); put(8'h23); put(8'h45); put_fill(4);
        run_case(8'h65, 1, 0, 32'h12345, 24, "R5", 0, -1);

        // R5: same stream with gapped valid
        put_magic(); put(8'h61); put(8'h00); put(8'h03); put_fill(3);
        put(8'h65); put(8'h00); put(8'h01); put(8'h23); put(8'h45); put_fill(4);
        run_case(8'h65, 1, 0, 32'h12345, 24, "R5", 1, -1);

        // R2: start mid-scan ignored
        put_magic(); put(8'h61); put(8'h00); put(8'h02); put_fill(2);
        put(8'h62); put(8'h00); put(8'h05); put_fill(5);
        run_case(8'h62, 1, 0, 32'd5, 21, "R2", 0, 14);

        // R4: skipped 4-byte field, zero-length section, then target
        put_magic(); put(8'h65); put(8'h00); put(8'h00); put(8'h00); put(8'h02); put_fill(2);
        put(8'h64); put(8'h00); put(8'h00);
        put(8'h62); put(8'h00); put(8'h02); put_fill(2);
        run_case(8'h62, 1, 0, 32'd2, 26, "R4", 0, -1);

        // R3: mismatch at position 5
        put_magic(); strm[5] = 8'h00; put_fill(8);
        run_case(8'h65, 0, 1, 32'd0, 6, "R3", 0, -1);

        // R3: mismatch at last signature byte
        put_magic(); strm[12] = 8'h02; put_fill(8);
        run_case(8'h65, 0, 1, 32'd0, 13, "R3", 0, -1);

        // R6: tag above range after a skipped section
        put_magic(); put(8'h61); put(8'h00); put(8'h01); put(8'h71); put(8'h7A); put_fill(4);
        run_case(8'h65, 0, 0, 32'd0, 18, "R6", 0, -1);

        // R6: tag just below range
        put_magic(); put(8'h60); put_fill(4);
        run_case(8'h65, 0, 0, 32'd0, 14, "R6", 0, -1);

        // R6: tag just above range
        put_magic(); put(8'h66); put_fill(4);
        run_case(8'h65, 0, 0, 32'd0, 14, "R6", 0, -1);

        // R7: 256 clamped to 64 when skipping
        put_magic(); put(8'h61); put(8'h01); put(8'h00); put_fill(64);
        put(8'h65); put(8'h00); put(8'h00); put(8'h00); put(8'h08); put_fill(4);
        run_case(8'h65, 1, 0, 32'd8, 85, "R7", 0, -1);

        // R7: reported clamp 200 -> 64, 65 -> 64, 63 kept
        put_magic(); put(8'h63); put(8'h00); put(8'hC8); put_fill(4);
        run_case(8'h63, 1, 0, 32'd64, 16, "R7", 0, -1);
        put_magic(); put(8'h63); put(8'h00); put(8'h41); put_fill(4);
        run_case(8'h63, 1, 0, 32'd64, 16, "R7", 0, -1);
        put_magic(); put(8'h63); put(8'h00); put(8'h3F); put_fill(4);
        run_case(8'h63, 1, 0, 32'd63, 16, "R7", 0, -1);

        // R8: long clamp around 307200
        put_magic(); put(8'h65); put(8'h00); put(8'h10); put(8'h00); put(8'h00); put_fill(4);
        run_case(8'h65, 1, 0, 32'd307200, 18, "R8", 0, -1);
        put_magic(); put(8'h65); put(8'h00); put(8'h04); put(8'hB0); put(8'h01); put_fill(4);
        run_case(8'h65, 1, 0, 32'd307200, 18, "R8", 0, -1);
        put_magic(); put(8'h65); put(8'h00); put(8'h04); put(8'hAF); put(8'hFF); put_fill(4);
        run_case(8'h65, 1, 0, 32'd307199, 18, "R8", 0, -1);

        // R9: window exhausted inside a skip
        put_magic(); put(8'h61); put(8'h00); put(8'h40); put_fill(64);
        put(8'h62); put(8'h00); put(8'h40); put_fill(64);
        put(8'h65); put(8'h00); put(8'h00); put(8'h00); put(8'h05); put_fill(4);
        run_case(8'h65, 0, 0, 32'd0, 113, "R9", 0, -1);

        // R9: tag read at count 99 still processed
        put_magic(); put(8'h61); put(8'h00); put(8'h40); put_fill(64);
        put(8'h61); put(8'h00); put(8'h1D); put_fill(29);
        put(8'h65); put(8'h00); put(8'h00); put(8'h00); put(8'h07); put_fill(4);
        run_case(8'h65, 1, 0, 32'd7, 117, "R9", 0, -1);

        chk("R5", "pending expectations", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule